// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell of a sum-of-products programmable logic array. A full device places eight copies of it. Each copy takes its group of product terms from the AND array, the global clock, the global active-low output-enable pin, the value at its own pad and the value at the neighbouring cell's pad. From these it produces three things: the value to drive onto the pad, the tri-state enable for that pad, and the feedback bit that returns to the array.

Four configuration bits set the cell's personality. Two are shared by the whole device: `cfg_glb_a`, which permits registers when low, and `cfg_glb_b`, which selects a register-style or combinational-style device. The other two are local: `cfg_loc_sel` picks the cell's variant, and `cfg_loc_inv` sets the output polarity. With these bits the cell becomes a registered output, a combinational output, a combinational I/O, or a dedicated input. Two parameters cover the cells that differ from the rest:
- `END_CELL` applies to the two outer cells. Their feedback selector is steered by the inverted first global bit.
- `NO_FB_SIMPLE` applies to the two cells that give no feedback in combinational-output mode.

The output register clears on the asynchronous power-up reset. It can also be loaded directly for test. The cell has no data stream, so every pin is a plain level signal with no valid/ready handshake.

Top module: `logic_macrocell`

## Requirements
- R1: The mode code is (cfg_glb_a, cfg_glb_b, cfg_loc_sel). 010 is registered output, 011 is I/O in a register-style device, 100 is combinational output, 101 is dedicated input and 111 is I/O in a combinational-style device. `mode_invalid_o` is 1 for the codes 000, 001 and 110, and 0 for every other code.
- R2: The sum is the OR of the terms in use, exclusive-ORed with `cfg_loc_inv`. A value of 0 gives the true sum and a value of 1 gives its complement.
- R3: The register loads the polarity-adjusted OR of all NTERMS terms on every rising clock edge. In registered mode `pin_o` equals the register and the feedback equals its complement.
- R4: In registered mode `pin_oe_o` is the inverse of `oe_pin_n_i`.
- R5: In both I/O modes, `pin_o` is the polarity-adjusted OR of terms 0..NTERMS-2, and `pin_oe_o` equals term NTERMS-1.
- R6: In combinational-output mode, `pin_o` uses all NTERMS terms and `pin_oe_o` is 1. When NO_FB_SIMPLE=1 the feedback in this mode is 0.
- R7: In dedicated-input mode, `pin_oe_o` is 0 and `pin_o` is 0.
- R8: The feedback selector uses the bit `cfg_glb_b`, or `~cfg_glb_a` when END_CELL=1. When that bit is 1, the feedback is the inverted register if cfg_loc_sel=0 and the own pad if cfg_loc_sel=1. When that bit is 0, the feedback is the adjacent pad. R6 overrides this rule.
- R9: A low `rst_n` clears the register at once, without waiting for a clock edge.
- R10: When `preload_en_i` is 1 at a rising edge, the register loads `preload_val_i` instead of the sum.
- R11: For an invalid code, the pin and the enable behave as in the I/O modes (R5), and the feedback follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up clear |
| cfg_glb_a | input | 1 | Global bit; 0 permits registers |
| cfg_glb_b | input | 1 | Global bit; register-style device |
| cfg_loc_sel | input | 1 | Local variant select |
| cfg_loc_inv | input | 1 | Local output polarity |
| terms_i | input | NTERMS | Product terms from the array |
| oe_pin_n_i | input | 1 | Global active-low output enable |
| pin_i | input | 1 | Value at this cell's pad |
| adj_pin_i | input | 1 | Value at the neighbour's pad |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | 1 | Test preload value |
| pin_o | output | 1 | Value to drive onto the pad |
| pin_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the array |
| mode_invalid_o | output | 1 | Unlisted mode code |

## Verification
The bench sweeps every mode code, both polarities, all 256 term patterns and every pad and output-enable combination. It runs this sweep on three variants at once: a plain cell, an end cell and a cell with feedback suppressed. This catches the most likely errors:
- An end cell that still steers its feedback by the second global bit returns its own pad instead of the neighbour's in the combinational-style I/O mode.
- A cell that ORs all eight terms in the I/O modes lets the enable term leak into the pad value.
- A swapped register feedback polarity shows up in every registered vector.

Directed steps confirm two timing points. Reset clears the register between clock edges, and a preload wins over the sum on the same edge.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  typedef enum logic [2:0] {
    MC_REG,
    MC_CIO_REGDEV,
    MC_COMB_OUT,
    MC_DED_IN,
    MC_CIO_COMBDEV,
    MC_UNDEF
  } mc_mode_e;
endpackage

// File: rtl/macrocell_mode_dec.sv
module macrocell_mode_dec
  import macrocell_pkg::*;
(
  input  logic     g_a_i,
  input  logic     g_b_i,
  input  logic     l_sel_i,
  output mc_mode_e mode_o,
  output logic     invalid_o
);
  always_comb begin
    unique case ({g_a_i, g_b_i, l_sel_i})
      3'b010:  mode_o = MC_REG;
      3'b011:  mode_o = MC_CIO_REGDEV;
      3'b100:  mode_o = MC_COMB_OUT;
      3'b101:  mode_o = MC_DED_IN;
      3'b111:  mode_o = MC_CIO_COMBDEV;
      default: mode_o = MC_UNDEF;
    endcase
  end
  assign invalid_o = (mode_o == MC_UNDEF);
endmodule

// File: rtl/macrocell_sum.sv
module macrocell_sum #(
  parameter int NTERMS = 8
) (
  input  logic [NTERMS-1:0] terms_i,
  input  logic              inv_i,
  output logic              sum_all_o,
  output logic              sum_part_o
);
  localparam int NPART = NTERMS - 1;
  logic [NPART-1:0] part_terms;
  assign part_terms = terms_i[NPART-1:0];
  assign sum_all_o  = (|terms_i) ^ inv_i;
  assign sum_part_o = (|part_terms) ^ inv_i;
endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  input  logic pre_en_i,
  input  logic pre_val_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_o <= 1'b0;
    else if (pre_en_i) q_o <= pre_val_i;
    else               q_o <= d_i;
  end

  // R3: sum captured on the edge when no preload is pending
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en_i |=> q_o == $past(d_i));
  // R10: preload overrides the sum
  a_r10_preload: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en_i |=> q_o == $past(pre_val_i));
endmodule

// File: rtl/macrocell_fb_mux.sv
module macrocell_fb_mux #(
  parameter bit END_CELL     = 1'b0,
  parameter bit NO_FB_SIMPLE = 1'b0
) (
  input  logic g_a_i,
  input  logic g_b_i,
  input  logic l_sel_i,
  input  logic comb_out_i,
  input  logic q_n_i,
  input  logic pin_i,
  input  logic adj_pin_i,
  output logic fb_o
);
  logic sel_bit;
  logic fb_raw;

  generate
    if (END_CELL) begin : g_end
      assign sel_bit = ~g_a_i;
    end else begin : g_mid
      assign sel_bit = g_b_i;
    end
  endgenerate

  assign fb_raw = sel_bit ? (l_sel_i ? pin_i : q_n_i) : adj_pin_i;

  generate
    if (NO_FB_SIMPLE) begin : g_nofb
      assign fb_o = comb_out_i ? 1'b0 : fb_raw;
    end else begin : g_fb
      assign fb_o = fb_raw;
    end
  endgenerate
endmodule

// File: rtl/logic_macrocell.sv
module logic_macrocell
  import macrocell_pkg::*;
#(
  parameter int NTERMS       = 8,
  parameter bit END_CELL     = 1'b0,
  parameter bit NO_FB_SIMPLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_glb_a,
  input  logic              cfg_glb_b,
  input  logic              cfg_loc_sel,
  input  logic              cfg_loc_inv,
  input  logic [NTERMS-1:0] terms_i,
  input  logic              oe_pin_n_i,
  input  logic              pin_i,
  input  logic              adj_pin_i,
  input  logic              preload_en_i,
  input  logic              preload_val_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fb_o,
  output logic              mode_invalid_o
);
  localparam int OE_TERM = NTERMS - 1;

  mc_mode_e mode;
  logic     sum_all, sum_part, q;

  macrocell_mode_dec u_dec (
    .g_a_i(cfg_glb_a), .g_b_i(cfg_glb_b), .l_sel_i(cfg_loc_sel),
    .mode_o(mode), .invalid_o(mode_invalid_o)
  );

  macrocell_sum #(.NTERMS(NTERMS)) u_sum (
    .terms_i(terms_i), .inv_i(cfg_loc_inv),
    .sum_all_o(sum_all), .sum_part_o(sum_part)
  );

  macrocell_reg u_reg (
    .clk(clk), .rst_n(rst_n), .d_i(sum_all),
    .pre_en_i(preload_en_i), .pre_val_i(preload_val_i), .q_o(q)
  );

  macrocell_fb_mux #(.END_CELL(END_CELL), .NO_FB_SIMPLE(NO_FB_SIMPLE)) u_fb (
    .g_a_i(cfg_glb_a), .g_b_i(cfg_glb_b), .l_sel_i(cfg_loc_sel),
    .comb_out_i(mode == MC_COMB_OUT), .q_n_i(~q),
    .pin_i(pin_i), .adj_pin_i(adj_pin_i), .fb_o(fb_o)
  );

  always_comb begin
    case (mode)
      MC_REG: begin
        pin_o    = q;
        pin_oe_o = ~oe_pin_n_i;
      end
      MC_COMB_OUT: begin
        pin_o    = sum_all;
        pin_oe_o = 1'b1;
      end
      MC_DED_IN: begin
        pin_o    = 1'b0;
        pin_oe_o = 1'b0;
      end
      default: begin
        pin_o    = sum_part;
        pin_oe_o = terms_i[OE_TERM];
      end
    endcase
  end

  // R7: dedicated input never drives and sees the neighbour pad
  a_r7_din_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MC_DED_IN) |-> (!pin_oe_o && fb_o == adj_pin_i));
  // R4: registered output follows the global enable pin
  a_r4_reg_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MC_REG) |-> (pin_oe_o == !oe_pin_n_i));
  // R5: I/O modes take the enable from the top term
  a_r5_cio_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MC_CIO_REGDEV || mode == MC_CIO_COMBDEV) |-> (pin_oe_o == terms_i[OE_TERM]));
  // R6: combinational output always drives
  a_r6_comb_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MC_COMB_OUT) |-> pin_oe_o);
  // R11: invalid codes use the term enable
  a_r11_undef_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mode_invalid_o |-> (pin_oe_o == terms_i[OE_TERM]));
endmodule

// File: tb/sim_logic_macrocell.sv
module sim_logic_macrocell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ga = 1'b0, gb = 1'b1, ls = 1'b0, li = 1'b0;
  logic [7:0] terms = 8'h00;
  logic       oen = 1'b1, pin = 1'b0, adj = 1'b0, pe = 1'b0, pv = 1'b0;
  logic [3:0] o0, o1, o2;
  logic       q_m;
  int         checks = 0, failures = 0;

  always #4 clk = ~clk;

  logic_macrocell #(.NTERMS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_glb_a(ga), .cfg_glb_b(gb), .cfg_loc_sel(ls),
    .cfg_loc_inv(li), .terms_i(terms), .oe_pin_n_i(oen), .pin_i(pin), .adj_pin_i(adj),
    .preload_en_i(pe), .preload_val_i(pv),
    .pin_o(o0[3]), .pin_oe_o(o0[2]), .fb_o(o0[1]), .mode_invalid_o(o0[0]));
  logic_macrocell #(.NTERMS(8), .END_CELL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_glb_a(ga), .cfg_glb_b(gb), .cfg_loc_sel(ls),
    .cfg_loc_inv(li), .terms_i(terms), .oe_pin_n_i(oen), .pin_i(pin), .adj_pin_i(adj),
    .preload_en_i(pe), .preload_val_i(pv),
    .pin_o(o1[3]), .pin_oe_o(o1[2]), .fb_o(o1[1]), .mode_invalid_o(o1[0]));
  logic_macrocell #(.NTERMS(8), .NO_FB_SIMPLE(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .cfg_glb_a(ga), .cfg_glb_b(gb), .cfg_loc_sel(ls),
    .cfg_loc_inv(li), .terms_i(terms), .oe_pin_n_i(oen), .pin_i(pin), .adj_pin_i(adj),
    .preload_en_i(pe), .preload_val_i(pv),
    .pin_o(o2[3]), .pin_oe_o(o2[2]), .fb_o(o2[1]), .mode_invalid_o(o2[0]));

  // register model from R3, R9, R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_m <= 1'b0;
    else if (pe) q_m <= pv;
    else         q_m <= (|terms) ^ li;
  end

  function automatic logic [3:0] expect_out(input bit endc, input bit nofb);
    logic [2:0] code;
    logic s8, s7, po, oe, fb, inv, sel;
    code = {ga, gb, ls};
    s8 = (|terms) ^ li;            // R2
    s7 = (|terms[6:0]) ^ li;
    sel = endc ? ~ga : gb;         // R8
    fb = sel ? (ls ? pin : ~q_m) : adj;
    inv = 1'b0;
    case (code)
      3'b010: begin po = q_m; oe = ~oen; end                  // R3, R4
      3'b011, 3'b111: begin po = s7; oe = terms[7]; end       // R5
      3'b100: begin po = s8; oe = 1'b1; if (nofb) fb = 1'b0; end // R6
      3'b101: begin po = 1'b0; oe = 1'b0; end                 // R7
      default: begin po = s7; oe = terms[7]; inv = 1'b1; end  // R1, R11
    endcase
    return {po, oe, fb, inv};
  endfunction

  function automatic string req_of(input logic [2:0] code);
    case (code)
      3'b010: return "R3/R4";
      3'b011: return "R5";
      3'b111: return "R5/R8";
      3'b100: return "R6";
      3'b101: return "R7";
      default: return "R1/R11";
    endcase
  endfunction

  task automatic check_vec(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s code=%b inv=%b terms=%h pin=%b adj=%b oen=%b act=%b exp=%b",
               tag, {ga, gb, ls}, li, terms, pin, adj, oen, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check_bit("R9 reset pin", o0[3], 1'b0);     // registered mode, cleared
    check_bit("R9 reset fb", o0[1], 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive sweep: polarity, mode code, terms, pads, OE pin (R1-R8, R11)
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int t = 0; t < 256; t++) begin
          for (int x = 0; x < 8; x++) begin
            @(negedge clk);
            li = p[0];
            {ga, gb, ls} = c[2:0];
            terms = t[7:0];
            {pin, adj, oen} = x[2:0];
            #2;
            check_vec({req_of(c[2:0]), " R2 plain"}, o0, expect_out(1'b0, 1'b0));
            check_vec({req_of(c[2:0]), " R8 end"},   o1, expect_out(1'b1, 1'b0));
            check_vec({req_of(c[2:0]), " R6 nofb"},  o2, expect_out(1'b0, 1'b1));
          end
        end
      end
    end

    // R10: preload wins over the sum
    @(negedge clk);
    {ga, gb, ls} = 3'b010; li = 1'b0; oen = 1'b0; terms = 8'h00;
    pe = 1'b1; pv = 1'b1;
    @(negedge clk); #2;
    check_bit("R10 preload one", o0[3], 1'b1);
    check_bit("R10 preload fb", o0[1], 1'b0);
    @(negedge clk);
    terms = 8'h81; pv = 1'b0;
    @(negedge clk); #2;
    check_bit("R10 preload zero", o0[3], 1'b0);
    @(negedge clk);
    pe = 1'b0;
    @(negedge clk); #2;
    check_bit("R3 capture after preload", o0[3], 1'b1);

    // R9: reset clears between edges
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check_bit("R9 async clear", o0[3], 1'b0);
    check_bit("R9 async clear end", o1[3], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check_bit("R3 recapture", o0[3], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule